// File: doc/BRIEF.md
# Programmable Divider Rate Generator

This block turns a 32.768 kHz timebase into a family of lower rates. A 15-stage binary counter runs on the timebase. A 4-bit rate code picks one of its stage outputs. That one tap feeds two consumers: a square-wave pin with its own enable, and a sticky periodic-event flag. The flag can drive an active-low interrupt line when its enable is set. The last stage gives a one-cycle pulse once per second, which starts the calendar update.

A 3-bit oscillator field gates the whole chain. Only the code 3'b010 lets the counter advance. Every other code holds the counter at zero. Any change of the field restarts the chain from zero, so software gets a known phase after writing it.

The block runs on the timebase clock, so one clock cycle is one timebase period. The interrupt output models an open-drain pin: a 0 pulls the line low and a 1 releases it.

Top module: `rategen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, sqw_out, pflag and sec_tick are 0, irq_n is 1 and irq_stat is 0.
- R2: While osc_ctl is not 3'b010, the chain stays at zero. Because of this no tap ever rises, sqw_out stays 0, pflag does not set and sec_tick does not pulse.
- R3: A change of osc_ctl clears the counter on the next edge. The counter then counts up by one per cycle from zero while osc_ctl stays at 3'b010.
- R4: Rate code 0 selects no tap, so sqw_out stays 0 and pflag never sets. Code 1 selects counter bit 6 (256 Hz). Code 2 selects counter bit 7 (128 Hz). Each code n from 3 to 15 selects counter bit n-2, which gives 8192 Hz at code 3 and 2 Hz at code 15. The selected tap has a period of 2^(bit+1) timebase cycles.
- R5: sqw_out equals the selected tap delayed by one register stage when sqw_en is 1. It is 0 one cycle after sqw_en is 0.
- R6: pflag sets one cycle after the selected tap rises, whatever the value of pie_en. It then stays set until stat_rd is sampled high.
- R7: A cycle with stat_rd high clears pflag. If a tap rise occurs in that same cycle, the set wins and pflag stays 1.
- R8: irq_n is 0 exactly when pflag and pie_en are both 1. irq_stat is always the inverse of irq_n.
- R9: sec_tick is a one-cycle pulse. It appears on the cycle after the counter has sat at its all-ones value while running, which is 2^15 cycles after a restart and every 2^15 cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one cycle per timebase period |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_ctl | input | 3 | Oscillator control field; 3'b010 runs the chain |
| rate_sel | input | 4 | Rate code that selects the divider tap |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic interrupt enable |
| stat_rd | input | 1 | Status read strobe; clears the periodic flag |
| sqw_out | output | 1 | Gated square wave |
| pflag | output | 1 | Sticky periodic-event flag |
| irq_n | output | 1 | Interrupt line, active low (0 = pull low, 1 = released) |
| irq_stat | output | 1 | Status bit reporting that the interrupt is asserted |
| sec_tick | output | 1 | One-second pulse for the calendar |

## Verification
The bench builds the block with its default 15-stage chain and run code 3'b010. With that build, every rate code can be selected, including the 2 Hz tap. The one-second pulse is also in reach: it needs one unbroken 2^15-cycle run, which the bench provides, followed by an explicit count of the pulses. Random changes to the oscillator field while the chain runs test restarts at arbitrary counter phases. Read strobes placed at random test the case where a read coincides with a tap edge.

// File: rtl/rategen_pkg.sv
package rategen_pkg;

    localparam logic [2:0] OSC_RUN = 3'b010;

    // Counter bit used by each rate code (code 0 has no tap).
    function automatic int tap_index(input int code);
        int idx;
        case (code)
            1:       idx = 6;
            2:       idx = 7;
            default: idx = code - 2;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/rategen_div.sv
module rategen_div #(
    parameter int         CNT_W    = 15,
    parameter logic [2:0] RUN_CODE = rategen_pkg::OSC_RUN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       osc_ctl,
    output logic [CNT_W-1:0] cnt,
    output logic             sec_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [2:0]       osc_prev;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    advance;

    always_comb begin
        st_d          = st_q;
        advance       = (osc_ctl == RUN_CODE) && (osc_ctl == st_q.osc_prev);
        st_d.osc_prev = osc_ctl;
        st_d.tick     = advance && (st_q.cnt == CNT_MAX);
        st_d.cnt      = advance ? st_q.cnt + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign sec_tick = st_q.tick;

    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_ctl != RUN_CODE) |=> (cnt == '0)); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_ctl != $past(osc_ctl)) |=> (cnt == '0)); // R3
    AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (cnt == '0)); // R9
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R9
endmodule

// File: rtl/rategen_tap.sv
module rategen_tap #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       rate_sel,
    input  logic             sqw_en,
    output logic             tap_now,
    output logic             sqw_out
);
    localparam int N_CODES = 16;

    typedef struct packed {
        logic sqw;
    } tap_st_t;

    tap_st_t             st_d, st_q;
    logic [N_CODES-1:0]  taps;

    for (genvar c = 0; c < N_CODES; c++) begin : g_tap
        localparam int IDX = rategen_pkg::tap_index(c);
        if (c == 0 || IDX >= CNT_W) begin : g_none
            assign taps[c] = 1'b0;
        end else begin : g_bit
            assign taps[c] = cnt[IDX];
        end
    end

    always_comb begin
        st_d     = st_q;
        tap_now  = taps[rate_sel];
        st_d.sqw = sqw_en && tap_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sqw_out = st_q.sqw;

    AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw_out); // R5
    AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0) |=> !sqw_out); // R4
endmodule

// File: rtl/rategen_pflag.sv
module rategen_pflag (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_now,
    input  logic stat_rd,
    input  logic pie_en,
    output logic pflag,
    output logic irq_n,
    output logic irq_stat
);
    typedef struct packed {
        logic tap_prev;
        logic flag;
    } pf_st_t;

    pf_st_t st_d, st_q;
    logic   rise;
    logic   irq_any;

    always_comb begin
        st_d          = st_q;
        rise          = tap_now && !st_q.tap_prev;
        st_d.tap_prev = tap_now;
        if (rise)         st_d.flag = 1'b1;
        else if (stat_rd) st_d.flag = 1'b0;
        irq_any       = st_q.flag && pie_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pflag    = st_q.flag;
    assign irq_n    = !irq_any;
    assign irq_stat = irq_any;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pflag && !stat_rd) |=> pflag); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tap_now) |=> !pflag); // R7
    AST_FLAG_NEEDS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pflag && !tap_now) |=> !pflag); // R6
endmodule

// File: rtl/rategen.sv
module rategen #(
    parameter int         CNT_W    = 15,
    parameter logic [2:0] RUN_CODE = rategen_pkg::OSC_RUN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] osc_ctl,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    input  logic       pie_en,
    input  logic       stat_rd,
    output logic       sqw_out,
    output logic       pflag,
    output logic       irq_n,
    output logic       irq_stat,
    output logic       sec_tick
);
    logic [CNT_W-1:0] cnt;
    logic             tap_now;

    rategen_div #(.CNT_W(CNT_W), .RUN_CODE(RUN_CODE)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_ctl  (osc_ctl),
        .cnt      (cnt),
        .sec_tick (sec_tick)
    );

    rategen_tap #(.CNT_W(CNT_W)) tap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .tap_now  (tap_now),
        .sqw_out  (sqw_out)
    );

    rategen_pflag pf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_now  (tap_now),
        .stat_rd  (stat_rd),
        .pie_en   (pie_en),
        .pflag    (pflag),
        .irq_n    (irq_n),
        .irq_stat (irq_stat)
    );

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_en |-> irq_n); // R8
    AST_STAT_INV: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat != irq_n); // R8
endmodule

// File: tb/rategen_tb_top.sv
module rategen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] osc_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       sqw_en = 1'b0;
    logic       pie_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       sqw_out, pflag, irq_n, irq_stat, sec_tick;

    int    n_vec = 0;
    int    n_bad = 0;
    int    n_cyc = 0;
    string ph = "R1";

    // bench reference state, built from the requirements
    logic [14:0] m_cnt = '0;
    logic [2:0]  m_prev = 3'b000;
    logic        m_sqw = 1'b0, m_tprev = 1'b0, m_flag = 1'b0, m_tick = 1'b0;

    always #4 clk = ~clk;

    rategen dut_i (
        .clk(clk), .rst_n(rst_n), .osc_ctl(osc_ctl), .rate_sel(rate_sel),
        .sqw_en(sqw_en), .pie_en(pie_en), .stat_rd(stat_rd),
        .sqw_out(sqw_out), .pflag(pflag), .irq_n(irq_n),
        .irq_stat(irq_stat), .sec_tick(sec_tick)
    );

    // R4 tap table
    function automatic int f_bit(input logic [3:0] code);
        if (code == 4'd1) return 6;
        if (code == 4'd2) return 7;
        return int'(code) - 2;
    endfunction

    function automatic logic f_tap(input logic [14:0] c, input logic [3:0] code);
        if (code == 4'd0) return 1'b0;
        return c[f_bit(code)];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk({ph, "/R5 sqw_out"},  sqw_out,  m_sqw);
        chk({ph, "/R6 pflag"},    pflag,    m_flag);
        chk({ph, "/R8 irq_n"},    irq_n,    !(m_flag && pie_en));
        chk({ph, "/R8 irq_stat"}, irq_stat, m_flag && pie_en);
        chk({ph, "/R9 sec_tick"}, sec_tick, m_tick);
    endtask

    // advance reference with current inputs, pass one edge, compare at negedge
    task automatic cyc();
        logic run, tn;
        run     = (osc_ctl == 3'b010) && (osc_ctl == m_prev);
        tn      = f_tap(m_cnt, rate_sel);
        m_sqw   = sqw_en && tn;
        if (tn && !m_tprev) m_flag = 1'b1;
        else if (stat_rd)   m_flag = 1'b0;
        m_tprev = tn;
        m_tick  = run && (m_cnt == 15'h7fff);
        m_cnt   = run ? m_cnt + 15'd1 : 15'd0;
        m_prev  = osc_ctl;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp=<190000", n_cyc);
            finish_run();
        end
    end

    initial begin
        int ticks;
        void'($urandom(32'd4242));

        // R1: reset state
        ph = "R1";
        repeat (3) @(negedge clk);
        chk("R1 sqw_out reset", sqw_out, 1'b0);
        chk("R1 pflag reset", pflag, 1'b0);
        chk("R1 irq_n reset", irq_n, 1'b1);
        chk("R1 irq_stat reset", irq_stat, 1'b0);
        chk("R1 sec_tick reset", sec_tick, 1'b0);
        rst_n = 1'b1;
        run_n(2);

        // R2: halted chain keeps all outputs quiet
        ph = "R2";
        osc_ctl = 3'b110; rate_sel = 4'd3; sqw_en = 1'b1; pie_en = 1'b1;
        run_n(300);
        osc_ctl = 3'b000;
        run_n(50);

        // R3: start, interrupt with another code, restart
        ph = "R3";
        osc_ctl = 3'b010;
        run_n(37);
        osc_ctl = 3'b011;
        run_n(5);
        osc_ctl = 3'b010;
        run_n(100);
        stat_rd = 1'b1; cyc(); stat_rd = 1'b0;

        // R4: sweep the rate codes with both enables on
        ph = "R4";
        for (int code = 0; code < 14; code++) begin
            int per;
            rate_sel = 4'(code);
            per = (code == 0) ? 200 : (2 << f_bit(4'(code)));
            run_n(2 * per + 60);
            stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
        end

        // R7: read held high while edges keep arriving
        ph = "R7";
        rate_sel = 4'd3;
        stat_rd = 1'b1;
        run_n(40);
        stat_rd = 1'b0;
        run_n(10);

        // R9: one unbroken second at code 15, count the pulses
        ph = "R9";
        rate_sel = 4'd15; pie_en = 1'b0;
        osc_ctl = 3'b001; cyc();
        osc_ctl = 3'b010;
        ticks = 0;
        for (int i = 0; i < 32768 + 40; i++) begin
            cyc();
            if (sec_tick) ticks++;
        end
        chk("R9 one pulse per 2^15 cycles", ticks == 1, 1'b1);

        // random mix
        ph = "RND";
        for (int i = 0; i < 60000; i++) begin
            if ($urandom_range(0, 2999) == 0)      osc_ctl = 3'($urandom);
            else if (osc_ctl != 3'b010 && $urandom_range(0, 199) == 0) osc_ctl = 3'b010;
            if ($urandom_range(0, 1999) == 0)      rate_sel = 4'($urandom_range(0, 11));
            if ($urandom_range(0, 499) == 0)       sqw_en = !sqw_en;
            if ($urandom_range(0, 499) == 0)       pie_en = !pie_en;
            stat_rd = ($urandom_range(0, 19) == 0);
            cyc();
        end
        stat_rd = 1'b0;

        finish_run();
    end
endmodule